// File: doc/BRIEF.md
# Transposed-Form FIR Filter

This block filters a stream of signed samples with a fixed set of tap weights chosen at elaboration. Each sample that arrives with its strobe raised is presented to every tap multiplier in the same cycle. The products feed a chain of adders with one register after each adder. The register nearest the output holds the filtered value, and that value appears one clock after the sample that produced it.

The registers sit between the adders instead of on the incoming samples. The longest combinational path is therefore one multiplier followed by one adder, whatever the tap count. The accumulator is wide enough that no sum can wrap. Cycles in which no sample is offered leave the filter state and the output unchanged, so a stream with gaps produces the same results as the same stream without them.

Top module: `fir_transposed`

## Requirements
- R1: For each accepted sample x[n], out_data equals the sum over k = 0..TAPS-1 of COEFS[k]·x[n-k], where x[n-k] counts only accepted samples and is zero for samples before the last reset.
- R2: out_valid is high in exactly the cycle after each cycle with in_valid high, and low otherwise.
- R3: out_data is AW = XW + CW + ceil(log2 TAPS) bits wide and two's complement signed. No partial sum ever overflows, including when every sample and every coefficient takes the most negative or most positive value.
- R4: A cycle with in_valid low has no effect. out_data keeps its value and the filter history does not move, so later outputs match a stream with the gap removed.
- R5: Synchronous reset sets out_valid and out_data to zero and clears the filter history, so the first outputs after reset see zero for all earlier samples.
- R6: A single accepted sample of value 1 followed by accepted zeros yields COEFS[0], COEFS[1], ..., COEFS[TAPS-1] on successive outputs, then zero.
- R7: The output for the sample accepted at clock edge n is present on out_data directly after edge n, with one register on the path from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; high means in_sample is accepted this cycle |
| in_sample | input | XW | Signed input sample |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| out_data | output | AW | Signed full-precision filter output |

## Verification
The overflow property assumes that COEFS and in_sample stay within their signed widths, which any value on the ports does. The bench drives full-scale positive and negative runs to reach the largest sums the filter can produce. The hold and delay properties assume in_valid is always 0 or 1 once reset has been applied. The bench drives every input from reset onward and places gaps of random length between samples. It also applies a reset in the middle of a stream, so the clearing of the history is checked on live data.

// File: rtl/fir_pkg.sv
package fir_pkg;
  // Accumulator width that can hold the sum of taps products without wrap.
  function automatic int fir_acc_width(input int xw, input int cw, input int taps);
    return xw + cw + $clog2(taps);
  endfunction
endpackage

// File: rtl/fir_tap_mult.sv
module fir_tap_mult #(
  parameter int XW = 16,
  parameter int CW = 16,
  parameter logic signed [CW-1:0] COEF = '0,
  localparam int PW = XW + CW
) (
  input  logic signed [XW-1:0] sample,
  output logic signed [PW-1:0] product
);
  function automatic logic signed [PW-1:0] smul(input logic signed [XW-1:0] a,
                                                input logic signed [CW-1:0] b);
    return a * b;
  endfunction

  assign product = smul(sample, COEF);
endmodule

// File: rtl/fir_sum_stage.sv
module fir_sum_stage #(
  parameter int PW = 32,
  parameter int AW = 35
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [PW-1:0] product,
  input  logic signed [AW-1:0] upstream,
  output logic signed [AW-1:0] acc
);
  // Add with one guard bit so that a wrap becomes visible as a named event.
  function automatic logic [AW:0] add_guard(input logic signed [PW-1:0] p,
                                            input logic signed [AW-1:0] u);
    logic [AW:0] pe;
    logic [AW:0] ue;
    pe = {{(AW + 1 - PW){p[PW-1]}}, p};
    ue = {u[AW-1], u};
    return pe + ue;
  endfunction

  logic [AW:0] sum_g;
  logic        sum_wrap;

  assign sum_g    = add_guard(product, upstream);
  assign sum_wrap = sum_g[AW] != sum_g[AW-1];

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= sum_g[AW-1:0];
  end

  // R3: an accepted sum never leaves the accumulator range
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    en |-> !sum_wrap);

  // R4: the stage holds when no sample is accepted
  a_r4_stage_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));
endmodule

// File: rtl/fir_valid_track.sv
module fir_valid_track (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic out_valid
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // R2: strobe follows the accepted sample by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

// File: rtl/fir_transposed.sv
module fir_transposed import fir_pkg::*; #(
  parameter int TAPS = 8,
  parameter int XW   = 16,
  parameter int CW   = 16,
  parameter logic signed [CW-1:0] COEFS [TAPS] = '{
    16'sd120, -16'sd340, 16'sd1500, 16'sd4000,
    16'sd4000, 16'sd1500, -16'sd340, 16'sd120},
  localparam int AW = fir_acc_width(XW, CW, TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [XW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);
  localparam int PW = XW + CW;

  logic signed [PW-1:0] tap_prod [TAPS];
  logic signed [AW-1:0] part     [TAPS + 1];

  assign part[TAPS] = '0;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    fir_tap_mult #(.XW(XW), .CW(CW), .COEF(COEFS[k])) u_mult (
      .sample  (in_sample),
      .product (tap_prod[k])
    );

    fir_sum_stage #(.PW(PW), .AW(AW)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .en       (in_valid),
      .product  (tap_prod[k]),
      .upstream (part[k + 1]),
      .acc      (part[k])
    );
  end

  fir_valid_track u_valid (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid)
  );

  assign out_data = part[0];

  // R5: reset leaves a cleared output and a low strobe
  a_r5_reset_clears: assert property (@(posedge clk)
    rst |=> (out_data == '0 && !out_valid));

  // R4: output data is frozen across a cycle without a sample
  a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
endmodule

// File: tb/sim_fir_transposed.sv
module sim_fir_transposed;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int XW = 16;
  localparam int AW = 35;
  localparam logic signed [15:0] BC [NT] = '{
    -16'sd1200, 16'sd32767, 16'sh8000, 16'sd517,
    16'sd0, -16'sd9, 16'sd20000, -16'sd3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [XW-1:0] in_sample = '0;
  logic out_valid;
  logic signed [AW-1:0] out_data;

  int nchk = 0;
  int nfail = 0;
  longint hist [NT];
  longint last_y = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fir_transposed #(.TAPS(NT), .XW(XW), .CW(16), .COEFS(BC)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_data(out_data));

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += longint'(BC[k]) * hist[k];
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    @(posedge clk); @(posedge clk); #1;
    for (int k = 0; k < NT; k++) hist[k] = 0;
    last_y = 0;
    chk("R5 out_valid after reset", longint'(out_valid), 0);
    chk("R5 out_data after reset", longint'(out_data), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  // One cycle: drive, let one edge pass, then compare (R7 latency of one register)
  task automatic step(input string req, input bit v, input longint x);
    @(negedge clk);
    in_valid = v; in_sample = x[XW-1:0];
    if (v) begin
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k - 1];
      hist[0] = longint'($signed(x[XW-1:0]));
      last_y = model();
    end
    @(posedge clk); #1;
    chk({req, " R2 strobe"}, longint'(out_valid), longint'(v));
    chk(v ? {req, " R1/R7 data"} : {req, " R4 hold"}, longint'(out_data), last_y);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NT; k++) hist[k] = 0;
    do_reset();

    // R6: unit impulse gives the coefficient list, then zero
    step("R6 impulse", 1'b1, 1);
    chk("R6 first tap", longint'(out_data), longint'(BC[0]));
    for (int i = 1; i < NT; i++) begin
      step("R6 impulse", 1'b1, 0);
      chk("R6 tap", longint'(out_data), longint'(BC[i]));
    end
    step("R6 tail", 1'b1, 0);
    chk("R6 tail zero", longint'(out_data), 0);

    // R4: impulse with gaps between samples
    step("R4 gapped impulse", 1'b1, -5);
    for (int i = 0; i < NT + 2; i++) begin
      step("R4 gap", 1'b0, 777);
      step("R4 gapped impulse", 1'b1, 0);
    end

    // R3: full-scale runs in both signs
    for (int i = 0; i < NT + 1; i++) step("R3 min run", 1'b1, -32768);
    for (int i = 0; i < NT + 1; i++) step("R3 max run", 1'b1, 32767);
    for (int i = 0; i < 2 * NT; i++) step("R3 alternating", 1'b1, (i % 2) ? 32767 : -32768);

    // R1: random stream with random gaps
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) step("R1 random gap", 1'b0, longint'($urandom_range(65535)) - 32768);
      step("R1 random", 1'b1, longint'($urandom_range(65535)) - 32768);
    end

    // R5: reset mid-stream, history must be clear
    do_reset();
    step("R5 after reset", 1'b1, 1);
    chk("R5 fresh history", longint'(out_data), longint'(BC[0]));
    for (int i = 0; i < 40; i++) step("R1 post reset", 1'b1, longint'($urandom_range(65535)) - 32768);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule